// File: doc/BRIEF.md
# Dithered Flyback PWM Controller

This block is the digital timing core of a primary-side flyback regulator. It drives the gate command of the primary power switch at a nominal fixed switching period. Once per period the period length is stepped along a slow triangular sweep, which spreads the switching energy over a wider band. The on-time of each period comes from a digitized compensation word. It is scaled to the period length and clamped to a maximum duty of roughly 55%, which keeps the transformer in discontinuous conduction under heavy load.

Two comparator flags protect the power stage. A primary overcurrent flag cuts the present on-time in the same cycle, and the switch may turn on again at the next period start. A secondary overvoltage flag shuts the switch off and latches a shutdown. The latch is released only by reset, or by the supply-good input going low and then high again. No switching occurs while supply-good is low.

Top module: `flyback_pwm_core`

## Requirements
- R1: During reset and right after it, `sw_gate`, `cycle_start`, `oc_trip` and `ov_shutdown` are all 0.
- R2: While `supply_ok` is 0, `sw_gate` stays 0 and no new period starts.
- R3: A period starts on the first clock edge at which switching is allowed. The duty word is sampled at that edge. `sw_gate` is then high for the first floor(min(duty_cmd, DUTY_MAX) * P / 2^DUTY_W) cycles of the period, where P is that period's length in cycles.
- R4: A duty word above DUTY_MAX (default 141 out of 256, about 55%) gives exactly the on-time of DUTY_MAX.
- R5: A duty word of 0 gives no high cycle in that period, while periods continue to start.
- R6: The period length is NOM_PERIOD + d. The offset d starts at 0, and each period start moves it by DITH_STEP in the current direction. The direction reverses when d reaches +DITH_AMP or -DITH_AMP. After reset the first period is NOM_PERIOD + DITH_STEP, so with the defaults the sequence is 102, 104, 106, 104, 102, 100, 98, 96, 94, 96.
- R7: When `oc_flag` is high, `sw_gate` is 0 in that same cycle and for the rest of the period. `oc_trip` reads 1 from the next cycle until the next period start, where it reads 0. The next period has its full on-time.
- R8: When `ov_flag` is high, `sw_gate` is 0 in that same cycle. If `supply_ok` is 1, `ov_shutdown` becomes 1 on the next cycle and stays 1 with no switching and no period start. It clears once `supply_ok` has been 0 for at least one clock edge, after which switching restarts.
- R9: `cycle_start` is high for exactly one cycle, the first cycle of each period, while the switch is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Input supply above its turn-on threshold |
| duty_cmd | input | DUTY_W | Compensation word; on-time fraction is duty_cmd / 2^DUTY_W |
| oc_flag | input | 1 | Primary switch current above its limit |
| ov_flag | input | 1 | Secondary voltage above its overvoltage threshold |
| sw_gate | output | 1 | Gate command for the primary switch |
| cycle_start | output | 1 | High in the first cycle of each period |
| oc_trip | output | 1 | On-time of the present period was cut by overcurrent |
| ov_shutdown | output | 1 | Latched overvoltage shutdown is active |

## Verification
A corrupted period counter or dither state shows up within one period as a spacing between `cycle_start` pulses that leaves the NOM_PERIOD ± DITH_AMP window or breaks the triangular sequence. A wrong on-time register shows up in the same period as a high run of `sw_gate` that differs from the scaled duty word or exceeds the clamp. A stuck overcurrent or overvoltage state shows up at the next period start as a nonzero `oc_trip` or a missing restart. The bench therefore measures each period edge to edge and compares both its length and its high count against a model of its own.

// File: rtl/flyback_pkg.sv
`timescale 1ns/1ps
package flyback_pkg;

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dith_dir_t;

  // Clamp the compensation word to the maximum duty code.
  function automatic int sat_duty(input int cmd, input int cap);
    return (cmd > cap) ? cap : cmd;
  endfunction

  // On-time in clock cycles for a clamped duty code and a period length.
  function automatic int on_cycles(input int dsat, input int per, input int w);
    return (dsat * per) >> w;
  endfunction

  // One step of the triangular sweep.
  function automatic int dither_next(input int off, input bit up, input int step);
    return up ? off + step : off - step;
  endfunction

endpackage

// File: rtl/flyback_dither.sv
`timescale 1ns/1ps
module flyback_dither #(
  parameter int AMP   = 6,
  parameter int STEP  = 2,
  parameter int OFF_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic signed [OFF_W-1:0] nxt_off
);
  import flyback_pkg::*;

  generate
    if (AMP == 0) begin : g_flat
      assign nxt_off = '0;
    end else begin : g_tri
      logic signed [OFF_W-1:0] off_q;
      dith_dir_t               dir_q, dir_n;
      int                      nxt;

      always_comb begin
        nxt = dither_next(int'(off_q), dir_q == DIR_UP, STEP);
        if (nxt >= AMP)       dir_n = DIR_DOWN;
        else if (nxt <= -AMP) dir_n = DIR_UP;
        else                  dir_n = dir_q;
      end

      assign nxt_off = OFF_W'(nxt);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          off_q <= '0;
          dir_q <= DIR_UP;
        end else if (adv) begin
          off_q <= nxt_off;
          dir_q <= dir_n;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/flyback_guard.sv
`timescale 1ns/1ps
module flyback_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic ov_flag,
  output logic run_en,
  output logic ov_latched
);
  logic ov_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          ov_q <= 1'b0;
    else if (!supply_ok) ov_q <= 1'b0;
    else                 ov_q <= ov_q | ov_flag;
  end

  assign run_en     = supply_ok & ~ov_q & ~ov_flag;
  assign ov_latched = ov_q;

endmodule

// File: rtl/flyback_period.sv
`timescale 1ns/1ps
module flyback_period #(
  parameter int NOM_PERIOD = 100,
  parameter int DUTY_W     = 8,
  parameter int DUTY_MAX   = 141,
  parameter int CNT_W      = 7,
  parameter int OFF_W      = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_en,
  input  logic [DUTY_W-1:0]       duty_cmd,
  input  logic                    oc_flag,
  input  logic signed [OFF_W-1:0] nxt_off,
  output logic                    load,
  output logic                    sw_gate,
  output logic                    cycle_start,
  output logic                    oc_trip
);
  import flyback_pkg::*;

  logic             active_q, start_q, oc_q;
  logic [CNT_W-1:0] cnt_q, per_len_q, on_len_q;
  logic             period_end;
  int               nxt_len_i, nxt_on_i;

  always_comb begin
    nxt_len_i = NOM_PERIOD + int'(nxt_off);
    nxt_on_i  = on_cycles(sat_duty(int'(duty_cmd), DUTY_MAX), nxt_len_i, DUTY_W);
  end

  assign period_end = active_q && (cnt_q == per_len_q - CNT_W'(1));
  assign load       = run_en && (!active_q || period_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      start_q   <= 1'b0;
      oc_q      <= 1'b0;
      cnt_q     <= '0;
      per_len_q <= '0;
      on_len_q  <= '0;
    end else if (!run_en) begin
      active_q  <= 1'b0;
      start_q   <= 1'b0;
      oc_q      <= 1'b0;
      cnt_q     <= '0;
      on_len_q  <= '0;
    end else if (load) begin
      active_q  <= 1'b1;
      start_q   <= 1'b1;
      oc_q      <= 1'b0;
      cnt_q     <= '0;
      per_len_q <= CNT_W'(nxt_len_i);
      on_len_q  <= CNT_W'(nxt_on_i);
    end else begin
      start_q   <= 1'b0;
      oc_q      <= oc_q | oc_flag;
      cnt_q     <= cnt_q + CNT_W'(1);
    end
  end

  assign sw_gate     = active_q & run_en & (cnt_q < on_len_q) & ~oc_q & ~oc_flag;
  assign cycle_start = start_q;
  assign oc_trip     = oc_q;

endmodule

// File: rtl/flyback_pwm_core.sv
`timescale 1ns/1ps
module flyback_pwm_core #(
  parameter int NOM_PERIOD = 100,
  parameter int DITH_AMP   = 6,
  parameter int DITH_STEP  = 2,
  parameter int DUTY_W     = 8,
  parameter int DUTY_MAX   = 141
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic              oc_flag,
  input  logic              ov_flag,
  output logic              sw_gate,
  output logic              cycle_start,
  output logic              oc_trip,
  output logic              ov_shutdown
);
  localparam int CNT_W = $clog2(NOM_PERIOD + DITH_AMP + 1);
  localparam int OFF_W = $clog2(DITH_AMP + 1) + 2;

  logic                    run_en;
  logic                    load;
  logic signed [OFF_W-1:0] nxt_off;

  flyback_guard u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .ov_flag    (ov_flag),
    .run_en     (run_en),
    .ov_latched (ov_shutdown)
  );

  flyback_dither #(
    .AMP   (DITH_AMP),
    .STEP  (DITH_STEP),
    .OFF_W (OFF_W)
  ) u_dither (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (load),
    .nxt_off (nxt_off)
  );

  flyback_period #(
    .NOM_PERIOD (NOM_PERIOD),
    .DUTY_W     (DUTY_W),
    .DUTY_MAX   (DUTY_MAX),
    .CNT_W      (CNT_W),
    .OFF_W      (OFF_W)
  ) u_period (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .duty_cmd    (duty_cmd),
    .oc_flag     (oc_flag),
    .nxt_off     (nxt_off),
    .load        (load),
    .sw_gate     (sw_gate),
    .cycle_start (cycle_start),
    .oc_trip     (oc_trip)
  );

endmodule

// File: rtl/flyback_pwm_chk.sv
`timescale 1ns/1ps
module flyback_pwm_chk #(
  parameter int NOM_PERIOD = 100,
  parameter int DITH_AMP   = 6,
  parameter int DUTY_W     = 8,
  parameter int DUTY_MAX   = 141
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic oc_flag,
  input logic ov_flag,
  input logic sw_gate,
  input logic cycle_start,
  input logic oc_trip,
  input logic ov_shutdown,
  input logic run_en
);
  localparam int CAP_LEN = (DUTY_MAX * (NOM_PERIOD + DITH_AMP)) >> DUTY_W;

  int   hi_cnt, gap_cnt;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt  <= 0;
      gap_cnt <= 0;
      seen    <= 1'b0;
    end else begin
      hi_cnt  <= sw_gate ? hi_cnt + 1 : 0;
      gap_cnt <= cycle_start ? 1 : gap_cnt + 1;
      seen    <= run_en ? (seen | cycle_start) : 1'b0;
    end
  end

  a_r2_off_when_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !sw_gate);

  a_r4_high_run_capped: assert property (@(posedge clk) disable iff (!rst_n)
    sw_gate |-> hi_cnt < CAP_LEN);

  a_r6_period_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && seen) |-> (gap_cnt >= NOM_PERIOD - DITH_AMP && gap_cnt <= NOM_PERIOD + DITH_AMP));

  a_r7_oc_cuts_now: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |-> !sw_gate);

  a_r7_rearm_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> !oc_trip);

  a_r8_ov_cuts_now: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag || ov_shutdown) |-> !sw_gate);

  a_r8_ov_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && supply_ok) |=> ov_shutdown);

  a_r8_ov_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_shutdown && supply_ok) |=> ov_shutdown);

  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !cycle_start);

endmodule

bind flyback_pwm_core flyback_pwm_chk #(
  .NOM_PERIOD (NOM_PERIOD),
  .DITH_AMP   (DITH_AMP),
  .DUTY_W     (DUTY_W),
  .DUTY_MAX   (DUTY_MAX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok   (supply_ok),
  .oc_flag     (oc_flag),
  .ov_flag     (ov_flag),
  .sw_gate     (sw_gate),
  .cycle_start (cycle_start),
  .oc_trip     (oc_trip),
  .ov_shutdown (ov_shutdown),
  .run_en      (run_en)
);

// File: tb/tb_flyback_pwm_core.sv
`timescale 1ns/1ps
module tb_flyback_pwm_core;
  localparam int NOM = 100, AMP = 6, STP = 2, DW = 8, DMAX = 141;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          supply_ok = 1'b0;
  logic [DW-1:0] duty_cmd = '0;
  logic          oc_flag = 1'b0;
  logic          ov_flag = 1'b0;
  logic          sw_gate, cycle_start, oc_trip, ov_shutdown;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  flyback_pwm_core #(
    .NOM_PERIOD (NOM), .DITH_AMP (AMP), .DITH_STEP (STP), .DUTY_W (DW), .DUTY_MAX (DMAX)
  ) dut (
    .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok), .duty_cmd (duty_cmd),
    .oc_flag (oc_flag), .ov_flag (ov_flag), .sw_gate (sw_gate),
    .cycle_start (cycle_start), .oc_trip (oc_trip), .ov_shutdown (ov_shutdown)
  );

  // Duty word and expected high cycles in the first period after reset (length 102).
  localparam int VEC_N = 8;
  localparam int VEC_D  [VEC_N] = '{0, 1, 3, 64, 128, 141, 200, 255};
  localparam int VEC_ON [VEC_N] = '{0, 0, 1, 25, 51,  56,  56,  56};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; supply_ok = 1'b0; oc_flag = 1'b0; ov_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Measures one whole period from one cycle_start to the next.
  task automatic measure(input int oc_at, output int on_c, output int len_c);
    int guard;
    on_c = 0; len_c = 0; guard = 0;
    #1;
    while (!cycle_start && guard < 1000) begin
      @(negedge clk); #1; guard++;
    end
    if (guard >= 1000) begin
      len_c = -1;
      return;
    end
    for (int idx = 0; idx < 1000; idx++) begin
      if (idx > 0 && cycle_start) break;
      oc_flag = (idx == oc_at);
      #1;
      on_c += int'(sw_gate);
      len_c++;
      @(negedge clk); oc_flag = 1'b0; #1;
    end
  endtask

  function automatic int exp_on(input int d, input int p);
    int ds;
    ds = (d > DMAX) ? DMAX : d;
    return (ds * p) / (1 << DW);
  endfunction

  initial begin
    int on_c, len_c, off, hits, starts;
    bit up;

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 sw_gate in reset", int'(sw_gate), 0);
    chk("R1 cycle_start in reset", int'(cycle_start), 0);
    chk("R1 oc_trip in reset", int'(oc_trip), 0);
    chk("R1 ov_shutdown in reset", int'(ov_shutdown), 0);

    // R2: supply not good -> nothing happens
    do_reset();
    duty_cmd = 8'd200;
    hits = 0; starts = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      hits += int'(sw_gate); starts += int'(cycle_start);
    end
    chk("R2 high cycles while unpowered", hits, 0);
    chk("R2 starts while unpowered", starts, 0);

    // R3 R4 R5: vector table, first period after reset
    for (int v = 0; v < VEC_N; v++) begin
      do_reset();
      duty_cmd = DW'(VEC_D[v]);
      supply_ok = 1'b1;
      measure(-1, on_c, len_c);
      chk($sformatf("R3 R4 R5 on-time duty=%0d", VEC_D[v]), on_c, VEC_ON[v]);
      chk($sformatf("R6 first period duty=%0d", VEC_D[v]), len_c, NOM + STP);
    end

    // R6 R9: ten consecutive periods follow the triangular sweep
    do_reset();
    duty_cmd = 8'd128;
    supply_ok = 1'b1;
    off = 0; up = 1'b1;
    for (int k = 0; k < 10; k++) begin
      off = up ? off + STP : off - STP;
      if (off >= AMP) up = 1'b0;
      else if (off <= -AMP) up = 1'b1;
      measure(-1, on_c, len_c);
      chk($sformatf("R6 R9 period %0d length", k), len_c, NOM + off);
      chk($sformatf("R3 period %0d on-time", k), on_c, exp_on(128, NOM + off));
    end

    // R7: overcurrent in cycle 10 of the first period
    do_reset();
    duty_cmd = 8'd128;
    supply_ok = 1'b1;
    measure(10, on_c, len_c);
    chk("R7 on-time cut by overcurrent", on_c, 10);
    chk("R7 period length unchanged", len_c, 102);
    chk("R7 oc_trip cleared at next start", int'(oc_trip), 0);
    measure(-1, on_c, len_c);
    chk("R7 full on-time in next period", on_c, exp_on(128, 104));

    // R8: overvoltage mid on-time
    repeat (5) @(negedge clk);
    ov_flag = 1'b1; #1;
    chk("R8 switch off in ov cycle", int'(sw_gate), 0);
    @(negedge clk); ov_flag = 1'b0; #1;
    chk("R8 shutdown latched", int'(ov_shutdown), 1);
    hits = 0; starts = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      hits += int'(sw_gate); starts += int'(cycle_start);
    end
    chk("R8 no switching while latched", hits, 0);
    chk("R8 no starts while latched", starts, 0);
    chk("R8 still latched", int'(ov_shutdown), 1);
    supply_ok = 1'b0;
    @(negedge clk); #1;
    chk("R8 latch cleared by supply drop", int'(ov_shutdown), 0);
    supply_ok = 1'b1;
    measure(-1, on_c, len_c);
    chk("R8 restart period in window", int'(len_c >= NOM - AMP && len_c <= NOM + AMP), 1);
    chk("R8 restart on-time", on_c, exp_on(128, len_c));

    // R2: supply drop during on-time turns the switch off at once
    repeat (3) @(negedge clk);
    supply_ok = 1'b0; #1;
    chk("R2 switch off on supply drop", int'(sw_gate), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule